// File: doc/BRIEF.md
# Debug Run-Control Register Block

This block is the part of a debug module that a debugger uses to stop, restart and reset hardware threads (harts). A debug transport presents single-word requests on a 7-bit address, and every request gets a response on the following cycle. A control word selects one hart and carries the halt, resume and reset requests. A status word summarises that hart: halted, running, unavailable, absent, resume acknowledged, reset seen. A summary window holds one halted bit for each hart.

The block drives per-hart halt, resume and reset lines plus one system reset line that leaves the debug logic alone. It watches the halted, running and unavailable state that each hart reports, and an external reset event per hart such as a watchdog. Per-hart reset is a build option. When it is left out, the reset bit reads back as 0, so software can find this out and use the system reset instead. A hart that leaves reset while its halt request is still set comes up halted. Resuming is a handshake: the request stays on the hart's line until that hart reports running, and an acknowledge flag in the status word then records that the resume completed.

Top module: `dbg_run_ctl`

## Requirements
- R1: After reset the control word reads 0, all halt, resume and reset outputs are low, no response is pending, and every hart's reset-seen flag is 1.
- R2: Every request produces rsp_valid exactly one cycle later. A read of address 0x10 returns the control word: bit 31 halt request, bit 30 resume request, bit 29 hart reset, bits 25:16 hart select, bit 1 system reset, bit 0 active. An address that is not mapped reads 0.
- R3: A control write with bit 0 equal to 0 clears every control field and ignores the other written bits. Fields load only from a write with bit 0 equal to 1.
- R4: halt_req is high only for the selected hart, and only while the halt request bit is 1. When the select points past the last hart, no halt_req line is high.
- R5: With HAS_HART_RESET=1, bit 29 drives hart_rst of the selected hart and reads back as 1. With HAS_HART_RESET=0, it reads 0 and drives nothing.
- R6: ndm_rst follows control bit 1.
- R7: A read of address 0x11 returns, for the selected hart: bits 3:0 equal to 2; bit 8 and bit 9 halted; bit 10 and bit 11 running; bit 12 and bit 13 unavailable; bit 14 and bit 15 set when the select is at or above NUM_HARTS (all other flags are then 0); bit 16 and bit 17 resume acknowledged; bit 18 and bit 19 reset seen.
- R8: A write with bit 30=1 and bit 31=0 clears the selected hart's resume acknowledge and raises its resume_req until that hart reports running. At that point resume_req falls and the acknowledge is set. A write with both bit 30 and bit 31 set stores no resume request and leaves the acknowledge unchanged.
- R9: A hart's reset-seen flag sets whenever its hart_rst, ndm_rst or hart_rst_evt is high. It is cleared only by a control write with bit 28=1 that selects that hart, and a reset in the same cycle wins over the clear.
- R10: Reads of 0x40+k (k from 0 to 31) return in bit j the halted input of hart 32k+j, and 0 for harts that do not exist.
- R11: A hart released from reset while its halt request is still set then reports halted, and the status word shows it halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| hart_halted | input | NUM_HARTS | Per-hart halted state |
| hart_running | input | NUM_HARTS | Per-hart running state |
| hart_unavail | input | NUM_HARTS | Per-hart unavailable state |
| hart_rst_evt | input | NUM_HARTS | Per-hart external reset event |
| halt_req | output | NUM_HARTS | Per-hart halt request |
| resume_req | output | NUM_HARTS | Per-hart resume request |
| hart_rst | output | NUM_HARTS | Per-hart reset |
| ndm_rst | output | 1 | System reset that spares the debug logic |

## Verification
The hardest case to reach is halting on exit from reset. It needs a hart model that goes quiet while reset is held, and a single control write that drops the reset bit but keeps the halt bit, so that the hart sees the halt request on the very cycle it leaves reset. The bench's hart models follow the output lines: they halt, run and go through reset on their own. The stimulus writes halt and reset together, checks that neither halted nor running is reported, and then releases only the reset. The resume handshake is driven the same way: the bench watches resume_req rise and then fall without any further write.

// File: rtl/dbg_rc_pkg.sv
package dbg_rc_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 10;

    localparam logic [ADDR_W-1:0] A_CTRL = 7'h10;
    localparam logic [ADDR_W-1:0] A_STAT = 7'h11;
    localparam logic [1:0]        HSUM_TOP = 2'b10;   // addr[6:5] of 0x40..0x5f

    localparam logic [3:0] STAT_VERSION = 4'd2;

    // control word bit positions (decoded by debugger software)
    localparam int B_HALT   = 31;
    localparam int B_RESUME = 30;
    localparam int B_HRST   = 29;
    localparam int B_ACKRST = 28;
    localparam int B_SEL_LO = 16;
    localparam int B_NDM    = 1;
    localparam int B_ACTIVE = 0;

    typedef struct packed {
        logic             haltreq;
        logic             resumereq;
        logic             hartreset;
        logic [SEL_W-1:0] sel;
        logic             ndmreset;
        logic             active;
    } ctrl_t;

    typedef struct packed {
        logic havereset;
        logic resumeack;
        logic absent;
        logic unavail;
        logic running;
        logic halted;
    } hart_view_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_HALT]                    = c.haltreq;
        w[B_RESUME]                  = c.resumereq;
        w[B_HRST]                    = c.hartreset;
        w[B_SEL_LO +: SEL_W]         = c.sel;
        w[B_NDM]                     = c.ndmreset;
        w[B_ACTIVE]                  = c.active;
        return w;
    endfunction

    // one selected hart: each "any" and "all" pair carries the same flag
    function automatic logic [DATA_W-1:0] pack_stat(input hart_view_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[3:0]   = STAT_VERSION;
        w[9:8]   = {2{v.halted}};
        w[11:10] = {2{v.running}};
        w[13:12] = {2{v.unavail}};
        w[15:14] = {2{v.absent}};
        w[17:16] = {2{v.resumeack}};
        w[19:18] = {2{v.havereset}};
        return w;
    endfunction

endpackage

// File: rtl/dbg_rc_ctrl.sv
module dbg_rc_ctrl
    import dbg_rc_pkg::*;
#(
    parameter bit HART_RESET_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              resume_go,
    output logic              ack_rst
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[27:26], wdata[15:2]};

    logic wr_live;
    assign wr_live   = wr_en && wdata[B_ACTIVE];
    assign resume_go = wr_live && wdata[B_RESUME] && !wdata[B_HALT];
    assign ack_rst   = wr_live && wdata[B_ACKRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (!wdata[B_ACTIVE]) begin
                ctrl_q <= '0;
            end else begin
                ctrl_q.active    <= 1'b1;
                ctrl_q.ndmreset  <= wdata[B_NDM];
                ctrl_q.sel       <= wdata[B_SEL_LO +: SEL_W];
                ctrl_q.haltreq   <= wdata[B_HALT];
                ctrl_q.resumereq <= wdata[B_RESUME] && !wdata[B_HALT];
                ctrl_q.hartreset <= HART_RESET_EN ? wdata[B_HRST] : 1'b0;
            end
        end
    end

    AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.active |-> (ctrl_q == '0)) else $error("inactive control holds a field"); // R3

    AST_RESUME_EXCLUDES_HALT: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.resumereq |-> !ctrl_q.haltreq) else $error("resume stored with halt"); // R8

    generate
        if (!HART_RESET_EN) begin : g_no_hrst
            AST_HRST_ABSENT: assert property (@(posedge clk) disable iff (rst)
                wr_en |=> !ctrl_q.hartreset) else $error("hart reset stored while absent"); // R5
        end
    endgenerate

endmodule

// File: rtl/dbg_rc_flags.sv
module dbg_rc_flags
    import dbg_rc_pkg::*;
#(
    parameter int NUM_HARTS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic                 resume_go,
    input  logic                 ack_rst,
    input  logic [NUM_HARTS-1:0] hart_rst,
    input  logic                 ndm_rst,
    input  logic [NUM_HARTS-1:0] rst_evt,
    input  logic [NUM_HARTS-1:0] running,
    output logic [NUM_HARTS-1:0] havereset,
    output logic [NUM_HARTS-1:0] resumeack,
    output logic [NUM_HARTS-1:0] pending
);

    genvar h;
    generate
        for (h = 0; h < NUM_HARTS; h++) begin : g_hart
            logic picked;
            logic rst_seen;
            assign picked   = (wr_sel == SEL_W'(h));
            assign rst_seen = hart_rst[h] || ndm_rst || rst_evt[h];

            always_ff @(posedge clk) begin
                if (rst) begin
                    havereset[h] <= 1'b1;
                end else if (rst_seen) begin
                    havereset[h] <= 1'b1;
                end else if (ack_rst && picked) begin
                    havereset[h] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    pending[h]   <= 1'b0;
                    resumeack[h] <= 1'b0;
                end else if (resume_go && picked) begin
                    pending[h]   <= 1'b1;
                    resumeack[h] <= 1'b0;
                end else if (!active) begin
                    pending[h]   <= 1'b0;
                end else if (pending[h] && running[h]) begin
                    pending[h]   <= 1'b0;
                    resumeack[h] <= 1'b1;
                end
            end

            AST_HAVERESET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
                rst_seen |=> havereset[h]) else $error("reset not recorded"); // R9

            AST_ACK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
                $rose(resumeack[h]) |-> $past(running[h])) else $error("ack without run"); // R8
        end
    endgenerate

endmodule

// File: rtl/dbg_rc_view.sv
module dbg_rc_view
    import dbg_rc_pkg::*;
#(
    parameter int NUM_HARTS = 8
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [4:0]           hsum_word,
    input  logic [NUM_HARTS-1:0] halted,
    input  logic [NUM_HARTS-1:0] running,
    input  logic [NUM_HARTS-1:0] unavail,
    input  logic [NUM_HARTS-1:0] havereset,
    input  logic [NUM_HARTS-1:0] resumeack,
    output hart_view_t           view,
    output logic [DATA_W-1:0]    hsum
);

    always_comb begin
        view        = '0;
        view.absent = 1'b1;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (sel == SEL_W'(h)) begin
                view.absent    = 1'b0;
                view.halted    = halted[h];
                view.running   = running[h];
                view.unavail   = unavail[h];
                view.havereset = havereset[h];
                view.resumeack = resumeack[h];
            end
        end
    end

    always_comb begin
        hsum = '0;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (hsum_word == 5'(h / 32)) begin
                hsum[h % 32] = halted[h];
            end
        end
    end

endmodule

// File: rtl/dbg_run_ctl.sv
module dbg_run_ctl
    import dbg_rc_pkg::*;
#(
    parameter int NUM_HARTS      = 8,
    parameter bit HAS_HART_RESET = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [6:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    input  logic [NUM_HARTS-1:0] hart_halted,
    input  logic [NUM_HARTS-1:0] hart_running,
    input  logic [NUM_HARTS-1:0] hart_unavail,
    input  logic [NUM_HARTS-1:0] hart_rst_evt,
    output logic [NUM_HARTS-1:0] halt_req,
    output logic [NUM_HARTS-1:0] resume_req,
    output logic [NUM_HARTS-1:0] hart_rst,
    output logic                 ndm_rst
);

    ctrl_t                ctrl_q;
    logic                 ctrl_wr, resume_go, ack_rst;
    logic [NUM_HARTS-1:0] havereset, resumeack, pending;
    hart_view_t           view;
    logic [DATA_W-1:0]    hsum, rd_word;

    assign ctrl_wr = req_valid && req_write && (req_addr == A_CTRL);

    dbg_rc_ctrl #(.HART_RESET_EN(HAS_HART_RESET)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(req_wdata),
        .ctrl_q(ctrl_q), .resume_go(resume_go), .ack_rst(ack_rst)
    );

    dbg_rc_flags #(.NUM_HARTS(NUM_HARTS)) u_flags (
        .clk(clk), .rst(rst), .active(ctrl_q.active),
        .wr_sel(req_wdata[B_SEL_LO +: SEL_W]),
        .resume_go(resume_go), .ack_rst(ack_rst),
        .hart_rst(hart_rst), .ndm_rst(ndm_rst), .rst_evt(hart_rst_evt),
        .running(hart_running),
        .havereset(havereset), .resumeack(resumeack), .pending(pending)
    );

    dbg_rc_view #(.NUM_HARTS(NUM_HARTS)) u_view (
        .sel(ctrl_q.sel), .hsum_word(req_addr[4:0]),
        .halted(hart_halted), .running(hart_running), .unavail(hart_unavail),
        .havereset(havereset), .resumeack(resumeack),
        .view(view), .hsum(hsum)
    );

    genvar h;
    generate
        for (h = 0; h < NUM_HARTS; h++) begin : g_out
            logic here;
            assign here          = (ctrl_q.sel == SEL_W'(h));
            assign halt_req[h]   = ctrl_q.haltreq && here;
            assign hart_rst[h]   = ctrl_q.hartreset && here;
            assign resume_req[h] = pending[h];
        end
    endgenerate

    assign ndm_rst = ctrl_q.ndmreset;

    always_comb begin
        rd_word = '0;
        if (req_addr == A_CTRL)            rd_word = pack_ctrl(ctrl_q);
        else if (req_addr == A_STAT)       rd_word = pack_stat(view);
        else if (req_addr[6:5] == HSUM_TOP) rd_word = hsum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) else $error("missing response"); // R2

    AST_ONE_HALT_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(halt_req)) else $error("several halt targets"); // R4

    AST_HRST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hart_rst)) else $error("several reset targets"); // R5

endmodule

// File: tb/test_dbg_run_ctl.sv
`timescale 1ns/1ps
module test_dbg_run_ctl;

    localparam int N = 8;
    localparam logic [31:0] V = 32'h2, HLT = 32'h300, RUN = 32'hC00,
        UNAV = 32'h3000, NONE = 32'hC000, RACK = 32'h30000, HRS = 32'hC0000;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_write = 0;
    logic [6:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic [N-1:0] m_halted = '0, m_running = '1, m_inrst = '0;
    logic [N-1:0] unavail = '0, rst_evt = '0;
    logic [N-1:0] halt_req, resume_req, hart_rst;
    logic ndm_rst;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    dbg_run_ctl #(.NUM_HARTS(N), .HAS_HART_RESET(1'b1)) i_dbg_run_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .hart_halted(m_halted), .hart_running(m_running), .hart_unavail(unavail),
        .hart_rst_evt(rst_evt), .halt_req(halt_req), .resume_req(resume_req),
        .hart_rst(hart_rst), .ndm_rst(ndm_rst)
    );

    // hart models
    always @(posedge clk) begin
        for (int h = 0; h < N; h++) begin
            if (rst) begin
                m_halted[h] <= 1'b0; m_running[h] <= 1'b1; m_inrst[h] <= 1'b0;
            end else if (hart_rst[h] || ndm_rst) begin
                m_halted[h] <= 1'b0; m_running[h] <= 1'b0; m_inrst[h] <= 1'b1;
            end else if (m_inrst[h]) begin
                m_inrst[h] <= 1'b0;
                m_halted[h] <= halt_req[h]; m_running[h] <= !halt_req[h];
            end else if (m_halted[h] && resume_req[h]) begin
                m_halted[h] <= 1'b0; m_running[h] <= 1'b1;
            end else if (m_running[h] && halt_req[h]) begin
                m_halted[h] <= 1'b1; m_running[h] <= 1'b0;
            end
        end
    end

    typedef struct { logic [31:0] exp; bit chk; string tag; } item_t;
    item_t sb[$];

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(rsp_rdata, 32'hx, "R2 unexpected response");
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.chk) chk(rsp_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic xfer(input bit wr, input logic [6:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input bit c, input string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        it.exp = exp; it.chk = c; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        xfer(1'b1, 7'h10, d, 32'h0, 1'b0, "");
    endtask
    task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
        xfer(1'b0, a, 32'h0, exp, 1'b1, tag);
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk({halt_req, resume_req, hart_rst}, '0, "R1 outputs after reset");
        chk({31'b0, ndm_rst}, 0, "R1 ndm after reset");
        rd(7'h10, 32'h0, "R1 control after reset");
        rd(7'h11, V | RUN | HRS, "R7 status hart0 after reset");
        // R4 halt hart 0
        wr(32'h8000_0001); idle(3);
        chk(32'(halt_req), 32'h01, "R4 halt hart0");
        rd(7'h11, V | HLT | HRS, "R7 hart0 halted");
        rd(7'h10, 32'h8000_0001, "R2 control readback");
        rd(7'h40, 32'h01, "R10 summary word0");
        // halt hart 5
        wr(32'h8005_0001); idle(3);
        chk(32'(halt_req), 32'h20, "R4 halt hart5 only");
        rd(7'h40, 32'h21, "R10 summary two harts");
        rd(7'h41, 32'h0, "R10 summary word1 absent harts");
        rd(7'h5f, 32'h0, "R10 last summary word");
        // R8 resume hart 5
        wr(32'h4005_0001);
        chk(32'(resume_req), 32'h20, "R8 resume raised");
        idle(4);
        chk(32'(resume_req), 32'h0, "R8 resume dropped on run");
        rd(7'h11, V | RUN | RACK | HRS, "R8 resume ack set");
        // R8 resume with halt ignored
        wr(32'h8005_0001); idle(3);
        wr(32'hC005_0001);
        chk(32'(resume_req), 32'h0, "R8 resume with halt ignored");
        rd(7'h10, 32'h8005_0001, "R8 resume bit not stored");
        rd(7'h11, V | HLT | RACK | HRS, "R8 ack untouched");
        // R9 acknowledge reset-seen
        wr(32'h9005_0001); idle(1);
        rd(7'h11, V | HLT | RACK, "R9 reset-seen cleared");
        @(negedge clk); rst_evt[5] = 1; @(negedge clk); rst_evt[5] = 0;
        rd(7'h11, V | HLT | RACK | HRS, "R9 external event sets flag");
        // R5 hart reset with halt held, R11
        wr(32'hA005_0001); idle(1);
        chk(32'(hart_rst), 32'h20, "R5 hart reset drives hart5");
        rd(7'h10, 32'hA005_0001, "R5 hart reset reads back");
        rd(7'h11, V | RACK | HRS, "R11 hart quiet in reset");
        wr(32'h8005_0001); idle(3);
        chk(32'(hart_rst), 32'h0, "R5 hart reset released");
        rd(7'h11, V | HLT | RACK | HRS, "R11 halted on reset exit");
        // R7 unavailable
        unavail[5] = 1;
        rd(7'h11, V | HLT | UNAV | RACK | HRS, "R7 unavailable");
        unavail[5] = 0;
        // R7/R4 absent hart
        wr(32'h800A_0001); idle(2);
        chk(32'(halt_req), 32'h0, "R4 no halt for absent hart");
        rd(7'h11, V | NONE, "R7 absent hart");
        // R6 system reset
        wr(32'h0000_0003); idle(1);
        chk({31'b0, ndm_rst}, 1, "R6 ndm raised");
        wr(32'h0000_0001); idle(3);
        chk({31'b0, ndm_rst}, 0, "R6 ndm released");
        rd(7'h11, V | RUN | HRS, "R9 system reset recorded");
        // R3 deactivate
        wr(32'h8003_0003); idle(1);
        wr(32'h0000_0000); idle(1);
        rd(7'h10, 32'h0, "R3 cleared by inactive write");
        chk({halt_req, 31'b0, ndm_rst}, '0, "R3 outputs low");
        wr(32'h8003_0000); idle(1);
        rd(7'h10, 32'h0, "R3 fields ignored while inactive");
        chk(32'(halt_req), 32'h0, "R3 no halt while inactive");
        rd(7'h20, 32'h0, "R2 unmapped address");
        idle(3);
        chk(sb.size(), 0, "R2 all responses seen");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule